// File: doc/BRIEF.md
# Parallel-Bus Converter Sequencer

This block is the host side of a successive-approximation converter that delivers its 16-bit result on a parallel bus. It drives the converter's active-low chip-select line and its read/convert line, and it watches the converter's BUSY line, which is low while a conversion runs. Each conversion starts with a setup phase. In that phase the read/convert line drops first, and only after a fixed number of cycles does chip select follow. After that single launch cycle both lines return high and stay high until BUSY rises, so the converter never sees a condition that would start a back-to-back conversion without acquiring a new input.

Once BUSY rises, the sequencer drops chip select with read/convert high. It waits a set number of cycles for the bus to settle and then samples the code. The code leaves the block on a valid/ready stream, either as it came from the bus (straight binary) or with its top bit flipped into two's-complement form. Conversions follow a start pulse, one per pulse, or repeat for as long as a continuous-mode input is held. A minimum spacing between launches gives the converter time to acquire the next input. A watchdog abandons a conversion whose BUSY never returns high.

Top module: `adc_conv_sequencer`

## Requirements
- R1: After reset, chip select (`adc_cs_n_o`) and read/convert (`adc_rc_o`) are both high, `res_valid_o` is low and `err_o` is low.
- R2: A conversion launch is a single cycle with both control lines low. Before it, read/convert is low with chip select high for exactly SETUP_CYC cycles.
- R3: From the cycle after the launch until the sequencer sees BUSY rise, both control lines are high, so at least one of them is high when BUSY rises.
- R4: Two launch cycles are never fewer than ACQ_CYC clock cycles apart.
- R5: Once a BUSY rise is seen, chip select is low with read/convert high for exactly SAMPLE_CYC cycles, and the bus is sampled in the last of them.
- R6: With `fmt_signed_i` low at the sampling cycle, the result equals the bus value (0000h is the most negative input, FFFFh the most positive).
- R7: With `fmt_signed_i` high at the sampling cycle, the result is the bus value with bit 15 inverted: 0000h becomes 8000h, FFFFh becomes 7FFFh and 8000h becomes 0000h.
- R8: A one-cycle `start_i` pulse requests exactly one conversion. A pulse that arrives while a conversion is in flight is held and served once. While `cont_i` is high, conversions repeat, and when it is low no new conversion begins without a request.
- R9: If BUSY does not rise within TIMEOUT_CYC cycles after the launch, `err_o` pulses high for one cycle, both control lines are high and no result is delivered.
- R10: `res_valid_o` stays high with `res_data_o` unchanged until `res_ready_i` is high, and no new conversion is launched while a result waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request one conversion |
| cont_i | input | 1 | Repeat conversions while high |
| fmt_signed_i | input | 1 | 1: two's-complement result, 0: straight binary |
| adc_busy_i | input | 1 | Converter BUSY, low during a conversion |
| adc_data_i | input | 16 | Converter parallel data bus |
| adc_cs_n_o | output | 1 | Converter chip select, active low |
| adc_rc_o | output | 1 | Converter read/convert line (low = convert) |
| res_valid_o | output | 1 | Result available |
| res_ready_i | input | 1 | Consumer accepts the result |
| res_data_o | output | 16 | Result code |
| err_o | output | 1 | One-cycle pulse when BUSY never rose |

## Verification
The bench goes after the launch order. A design that dropped both lines together, or chip select first, would give the wrong setup count in front of the launch. A design that released only one line after the launch would be caught when BUSY rises. The format corners are checked with 0000h, FFFFh, 8000h and 7FFFh: flipping the wrong bit or negating the code instead of offsetting it would misreport those values. Further runs cover a start that arrives during a conversion, which a design might drop or serve twice, a stalled consumer, which a design might overwrite or bypass with a new launch, and a converter that never answers, which must end in one error pulse rather than a hang or a phantom result.

// File: rtl/seq_pkg.sv
// Package: shared state encoding for the converter sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,   // both lines high, waiting for a request
        ST_SETUP  = 3'd1,   // read/convert low ahead of chip select
        ST_LAUNCH = 3'd2,   // both low: conversion starts
        ST_WAIT   = 3'd3,   // both high until BUSY rises
        ST_READ   = 3'd4,   // chip select low, read/convert high
        ST_HOLD   = 3'd5    // result offered on the output stream
    } seq_state_t;

endpackage

// File: rtl/seq_down_counter.sv
// Module: loadable down counter that stops at zero.
// Assumes: load wins over decrement; decrement below zero is prevented by the user.
module seq_down_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] value_i,
    input  logic         dec_i,
    output logic         zero_o
);

    logic [W-1:0] cnt_q;

    // count register: reset, load or step down
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= value_i;
        end else if (dec_i) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // zero flag for the owner's state machine
    always_comb begin
        zero_o = (cnt_q == '0);
    end

endmodule

// File: rtl/seq_code_fmt.sv
// Module: maps a straight-binary code to two's complement when asked.
// Assumes: offset-binary input, so inverting the top bit re-centres the code.
module seq_code_fmt #(
    parameter int W = 16
) (
    input  logic [W-1:0] raw_i,
    input  logic         to_signed_i,
    output logic [W-1:0] code_o
);

    // invert the most significant bit only in signed mode
    always_comb begin
        code_o = {raw_i[W-1] ^ to_signed_i, raw_i[W-2:0]};
    end

endmodule

// File: rtl/adc_conv_sequencer.sv
// Module: host-side sequencer for a parallel-output converter.
// Orders the control lines, spaces conversions, watches BUSY, samples the
// bus and offers each code on a valid/ready stream.
// Assumes: every *_CYC parameter is at least 1; adc_busy_i is synchronous to clk.
module adc_conv_sequencer
    import seq_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int ACQ_CYC     = 1250,
    parameter int SETUP_CYC   = 2,
    parameter int SAMPLE_CYC  = 3,
    parameter int TIMEOUT_CYC = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              cont_i,
    input  logic              fmt_signed_i,
    input  logic              adc_busy_i,
    input  logic [DATA_W-1:0] adc_data_i,
    output logic              adc_cs_n_o,
    output logic              adc_rc_o,
    output logic              res_valid_o,
    input  logic              res_ready_i,
    output logic [DATA_W-1:0] res_data_o,
    output logic              err_o
);

    localparam int STEP_MAX = (SETUP_CYC > SAMPLE_CYC) ? SETUP_CYC : SAMPLE_CYC;
    localparam int GAP_W    = $clog2(ACQ_CYC + 1);
    localparam int STEP_W   = $clog2(STEP_MAX + 1);
    localparam int WD_W     = $clog2(TIMEOUT_CYC + 1);
    localparam logic [GAP_W-1:0]  GAP_LOAD    = GAP_W'(ACQ_CYC - 1);
    localparam logic [STEP_W-1:0] SETUP_LOAD  = STEP_W'(SETUP_CYC - 1);
    localparam logic [STEP_W-1:0] SAMPLE_LOAD = STEP_W'(SAMPLE_CYC - 1);
    localparam logic [WD_W-1:0]   WD_LOAD     = WD_W'(TIMEOUT_CYC - 1);

    seq_state_t        st_q;
    logic              busy_q;
    logic              pend_q;
    logic              err_q;
    logic [DATA_W-1:0] res_q;
    logic [DATA_W-1:0] code_w;
    logic              busy_rise;
    logic              take;
    logic              gap_zero;
    logic              step_zero;
    logic              wd_zero;
    logic              step_load;
    logic [STEP_W-1:0] step_val;

    // request decode and BUSY edge detection
    always_comb begin
        busy_rise = adc_busy_i & ~busy_q;
        take      = (st_q == ST_IDLE) && (start_i || pend_q || cont_i) && gap_zero;
        step_load = take || ((st_q == ST_WAIT) && busy_rise);
        step_val  = take ? SETUP_LOAD : SAMPLE_LOAD;
    end

    // spacing between launches
    seq_down_counter #(.W(GAP_W)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (st_q == ST_LAUNCH),
        .value_i (GAP_LOAD),
        .dec_i   (!gap_zero),
        .zero_o  (gap_zero)
    );

    // setup and sampling delays share one counter
    seq_down_counter #(.W(STEP_W)) u_step (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (step_load),
        .value_i (step_val),
        .dec_i   (((st_q == ST_SETUP) || (st_q == ST_READ)) && !step_zero),
        .zero_o  (step_zero)
    );

    // watchdog on the BUSY return
    seq_down_counter #(.W(WD_W)) u_wd (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (st_q == ST_LAUNCH),
        .value_i (WD_LOAD),
        .dec_i   ((st_q == ST_WAIT) && !wd_zero),
        .zero_o  (wd_zero)
    );

    // output code formatting
    seq_code_fmt #(.W(DATA_W)) u_fmt (
        .raw_i       (adc_data_i),
        .to_signed_i (fmt_signed_i),
        .code_o      (code_w)
    );

    // BUSY history register, idle level is high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b1;
        end else begin
            busy_q <= adc_busy_i;
        end
    end

    // single-shot request memory
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (take) begin
            pend_q <= 1'b0;
        end else if (start_i) begin
            pend_q <= 1'b1;
        end
    end

    // sequencing state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE:   if (take) st_q <= ST_SETUP;
                ST_SETUP:  if (step_zero) st_q <= ST_LAUNCH;
                ST_LAUNCH: st_q <= ST_WAIT;
                ST_WAIT: begin
                    if (busy_rise) begin
                        st_q <= ST_READ;
                    end else if (wd_zero) begin
                        st_q <= ST_IDLE;
                    end
                end
                ST_READ:   if (step_zero) st_q <= ST_HOLD;
                ST_HOLD:   if (res_ready_i) st_q <= ST_IDLE;
                default:   st_q <= ST_IDLE;
            endcase
        end
    end

    // result capture on the last sampling cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else if ((st_q == ST_READ) && step_zero) begin
            res_q <= code_w;
        end
    end

    // one-cycle timeout flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else begin
            err_q <= (st_q == ST_WAIT) && !busy_rise && wd_zero;
        end
    end

    // control lines and stream outputs from state
    always_comb begin
        adc_cs_n_o  = !((st_q == ST_LAUNCH) || (st_q == ST_READ));
        adc_rc_o    = !((st_q == ST_SETUP) || (st_q == ST_LAUNCH));
        res_valid_o = (st_q == ST_HOLD);
        res_data_o  = res_q;
        err_o       = err_q;
    end

endmodule

// File: rtl/seq_checker.sv
// Module: protocol checker for adc_conv_sequencer, attached by bind.
// Assumes: the same ACQ_CYC as the checked instance.
module seq_checker #(
    parameter int DATA_W  = 16,
    parameter int ACQ_CYC = 1250
) (
    input logic              clk,
    input logic              rst_n,
    input logic              adc_cs_n_o,
    input logic              adc_rc_o,
    input logic              adc_busy_i,
    input logic              res_valid_o,
    input logic              res_ready_i,
    input logic [DATA_W-1:0] res_data_o,
    input logic              err_o
);

    localparam int SINCE_W = $clog2(ACQ_CYC + 1);

    logic               launch;
    logic               seen_q;
    logic [SINCE_W-1:0] since_q;

    // launch cycle decode
    always_comb begin
        launch = !adc_cs_n_o && !adc_rc_o;
    end

    // cycles since the previous launch, saturating
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q <= '0;
            seen_q  <= 1'b0;
        end else if (launch) begin
            since_q <= SINCE_W'(1);
            seen_q  <= 1'b1;
        end else if (since_q < SINCE_W'(ACQ_CYC)) begin
            since_q <= since_q + 1'b1;
        end
    end

    assert_setup_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(adc_cs_n_o) && !adc_rc_o) |-> ($past(adc_cs_n_o) && !$past(adc_rc_o)));

    assert_launch_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> (adc_cs_n_o && adc_rc_o));

    assert_ctrl_high_at_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_busy_i) |-> (adc_cs_n_o || adc_rc_o));

    assert_launch_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && seen_q) |-> (since_q >= SINCE_W'(ACQ_CYC)));

    assert_err_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o);

    assert_err_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (adc_cs_n_o && adc_rc_o && !res_valid_o));

    assert_hold_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && !res_ready_i) |=> (res_valid_o && $stable(res_data_o)));

endmodule

bind adc_conv_sequencer seq_checker #(
    .DATA_W  (DATA_W),
    .ACQ_CYC (ACQ_CYC)
) u_seq_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .adc_cs_n_o  (adc_cs_n_o),
    .adc_rc_o    (adc_rc_o),
    .adc_busy_i  (adc_busy_i),
    .res_valid_o (res_valid_o),
    .res_ready_i (res_ready_i),
    .res_data_o  (res_data_o),
    .err_o       (err_o)
);

// File: tb/test_adc_conv_sequencer.sv
// Bench: converter model, behavioural reference model compared every cycle,
// plus event monitors for ordering, spacing and result values.
module test_adc_conv_sequencer;

    localparam int ACQ     = 1250;
    localparam int SETUP   = 2;
    localparam int SAMPLE  = 3;
    localparam int TIMEOUT = 2000;
    localparam int CONV    = 50;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        cont = 1'b0;
    logic        fmt = 1'b0;
    logic        ready = 1'b1;
    logic        busy = 1'b1;
    logic [15:0] bus = 16'h0000;
    logic        cs_n, rc, valid, err;
    logic [15:0] data;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 1'b0;

    adc_conv_sequencer #(
        .DATA_W(16), .ACQ_CYC(ACQ), .SETUP_CYC(SETUP),
        .SAMPLE_CYC(SAMPLE), .TIMEOUT_CYC(TIMEOUT)
    ) i_adc_conv_sequencer (
        .clk(clk), .rst_n(rst_n), .start_i(start), .cont_i(cont),
        .fmt_signed_i(fmt), .adc_busy_i(busy), .adc_data_i(bus),
        .adc_cs_n_o(cs_n), .adc_rc_o(rc), .res_valid_o(valid),
        .res_ready_i(ready), .res_data_o(data), .err_o(err)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    // converter model: codes served in order, optional dead mode
    logic [15:0] codes [8];
    int adc_idx = 0;
    int adc_left = 0;
    bit adc_dead = 1'b0;
    initial begin
        codes[0] = 16'h0000; codes[1] = 16'hFFFF; codes[2] = 16'h8000; codes[3] = 16'h7FFF;
        codes[4] = 16'h1234; codes[5] = 16'hA5C3; codes[6] = 16'h0001; codes[7] = 16'hFFFE;
    end
    always @(negedge clk) begin
        if (adc_left > 0) begin
            adc_left--;
            if (adc_left == 0) begin
                chk("R3 lines high at busy rise", {31'd0, cs_n & rc}, 32'd1);
                busy = 1'b1;
                bus = codes[adc_idx % 8];
                adc_idx++;
            end
        end else if (!adc_dead && busy && !cs_n && !rc) begin
            busy = 1'b0;
            adc_left = CONV;
        end
    end

    // reference model, advanced on each rising edge from the bench's inputs
    int m_ph = 0, m_step = 0, m_gap = 0, m_wd = 0;
    bit m_pend = 0, m_busy_q = 1, m_err = 0;
    logic [15:0] m_res = 16'h0;
    int hs = 0;
    logic [15:0] got [$];
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_ph = 0; m_step = 0; m_gap = 0; m_wd = 0;
            m_pend = 0; m_busy_q = 1; m_err = 0; m_res = 16'h0;
        end else begin
            bit rise, gz, tk, nerr;
            if (valid && ready) begin
                got.push_back(data);
                hs++;
            end
            rise = busy && !m_busy_q;
            m_busy_q = busy;
            gz = (m_gap == 0);
            if (!gz) m_gap--;
            tk = (m_ph == 0) && (start || m_pend || cont) && gz;
            nerr = 0;
            case (m_ph)
                0: if (tk) begin m_ph = 1; m_step = SETUP - 1; end
                1: if (m_step == 0) m_ph = 2; else m_step--;
                2: begin m_ph = 3; m_wd = TIMEOUT - 1; m_gap = ACQ - 1; end
                3: begin
                    if (rise) begin m_ph = 4; m_step = SAMPLE - 1; end
                    else if (m_wd == 0) begin m_ph = 0; nerr = 1; end
                    else m_wd--;
                end
                4: if (m_step == 0) begin
                       m_res = fmt ? (bus ^ 16'h8000) : bus;
                       m_ph = 5;
                   end else m_step--;
                default: if (ready) m_ph = 0;
            endcase
            if (tk) m_pend = 0; else if (start) m_pend = 1;
            m_err = nerr;
        end
        if (cyc > 150000) begin
            tests++; fails++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
            finish_run();
        end
    end

    // per-cycle comparison and event monitors
    bit run = 0;
    int setup_run = 0, read_run = 0, launches = 0, last_launch = -1;
    always @(negedge clk) begin
        if (run && rst_n) begin
            chk("R2 cs_n vs model", {31'd0, cs_n}, {31'd0, !(m_ph == 2 || m_ph == 4)});
            chk("R3 rc vs model", {31'd0, rc}, {31'd0, !(m_ph == 1 || m_ph == 2)});
            chk("R10 valid vs model", {31'd0, valid}, {31'd0, m_ph == 5});
            chk("R6 data vs model", {16'd0, data}, {16'd0, m_res});
            chk("R9 err vs model", {31'd0, err}, {31'd0, m_err});
            if (!cs_n && !rc) begin
                chk("R2 setup length", setup_run, SETUP);
                if (last_launch >= 0) chk("R4 spacing ok", {31'd0, (cyc - last_launch) >= ACQ}, 32'd1);
                last_launch = cyc;
                launches++;
            end
            setup_run = (cs_n && !rc) ? setup_run + 1 : 0;
            if (!cs_n && rc) read_run++;
            else if (read_run != 0) begin
                chk("R5 read length", read_run, SAMPLE);
                read_run = 0;
            end
        end
    end

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_hs(input int n);
        while (hs < n && cyc < 140000) @(negedge clk);
    endtask

    initial begin
        int n;
        bit seen_err;
        repeat (5) @(negedge clk);
        chk("R1 reset cs_n", {31'd0, cs_n}, 32'd1);
        chk("R1 reset rc", {31'd0, rc}, 32'd1);
        chk("R1 reset valid", {31'd0, valid}, 32'd0);
        chk("R1 reset err", {31'd0, err}, 32'd0);
        rst_n = 1'b1;
        run = 1'b1;
        @(negedge clk);

        // two single requests, the second while the first is in flight (R8)
        fmt = 1'b0;
        pulse_start();
        repeat (10) @(negedge clk);
        pulse_start();
        wait_hs(2);
        chk("R8 queued start served", hs, 2);

        // continuous mode, signed format
        fmt = 1'b1;
        cont = 1'b1;
        wait_hs(5);
        cont = 1'b0;
        n = launches;
        repeat (3000) @(negedge clk);
        chk("R8 no launch without request", launches, n);

        // stalled consumer with continuous mode requested (R10)
        ready = 1'b0;
        cont = 1'b1;
        while (!valid && cyc < 140000) @(negedge clk);
        n = launches;
        repeat (3000) @(negedge clk);
        chk("R10 valid held", {31'd0, valid}, 32'd1);
        chk("R10 no launch while stalled", launches, n);
        cont = 1'b0;
        ready = 1'b1;
        wait_hs(6);

        // converter never answers (R9)
        adc_dead = 1'b1;
        n = hs;
        pulse_start();
        seen_err = 0;
        for (int i = 0; i < 6000 && !seen_err; i++) begin
            @(negedge clk);
            if (err) seen_err = 1;
        end
        chk("R9 timeout flagged", {31'd0, seen_err}, 32'd1);
        @(negedge clk);
        chk("R9 lines high after timeout", {30'd0, cs_n, rc}, 32'd3);
        repeat (20) @(negedge clk);
        chk("R9 no result on timeout", hs, n);
        adc_dead = 1'b0;

        // straight binary again after recovery
        fmt = 1'b0;
        pulse_start();
        wait_hs(7);

        chk("R6 got count", got.size(), 7);
        if (got.size() == 7) begin
            chk("R6 unsigned 0000h", {16'd0, got[0]}, 32'h0000);
            chk("R6 unsigned FFFFh", {16'd0, got[1]}, 32'hFFFF);
            chk("R7 signed 8000h->0000h", {16'd0, got[2]}, 32'h0000);
            chk("R7 signed 7FFFh->FFFFh", {16'd0, got[3]}, 32'hFFFF);
            chk("R7 signed 1234h", {16'd0, got[4]}, 32'h9234);
            chk("R7 signed A5C3h", {16'd0, got[5]}, 32'h25C3);
            chk("R6 unsigned 0001h", {16'd0, got[6]}, 32'h0001);
        end
        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule